// File: doc/BRIEF.md
# Branch and Skip Condition Evaluator

This block decides the outcome of conditional control-flow instructions for a small 8-bit RISC core. Each cycle in which a request is presented, it looks at the kind of instruction, the status register, the relevant operands and the current program counter. It then reports whether the instruction changes the flow, which program counter follows, and how many cycles the instruction uses.

Two families are handled. Relative branches test one status flag, selected by a 3-bit index, and jump when that flag is set (or, in the other variant, when it is clear). Skips test the equality of two registers, one bit of a register, or one bit of an I/O register, and step over the following instruction. Stepping over it costs one or two extra words depending on whether that instruction is one or two words long. The signed flag is always derived from the negative and overflow flags rather than read from its stored copy. All results are registered, so the outcome of a request appears one clock later.

Top module: `branch_skip_eval`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `out_taken`, `out_cycles` and `out_next_pc` read 0.
- R2: Kind 0 (branch-if-set) is taken when status bit `in_sel` is 1, and kind 1 (branch-if-clear) is taken when it is 0. The status bit order from bit 0 to bit 7 is C, Z, N, V, S, H, T, I.
- R3: For a branch with `in_sel` = 4 the tested flag is N XOR V (status bits 2 and 3), and the stored status bit 4 has no effect.
- R4: A taken branch gives `out_next_pc` = `in_pc` + sign-extended 7-bit `in_k` + 1, modulo 2^PCW, and `out_cycles` = 2.
- R5: A branch not taken, a skip whose condition is false, and the reserved kind 7 give `out_taken` = 0, `out_next_pc` = `in_pc` + 1 modulo 2^PCW and `out_cycles` = 1.
- R6: Kind 2 (skip-if-equal) is taken when `in_opa` equals `in_opb`.
- R7: Kind 3 skips when bit `in_sel` of `in_opa` is 0, and kind 4 skips when that bit is 1.
- R8: Kind 5 skips when bit `in_sel` of `in_io` is 0, and kind 6 skips when that bit is 1.
- R9: A taken skip with `in_next_long` = 0 gives `in_pc` + 2 and 2 cycles. With `in_next_long` = 1 it gives `in_pc` + 3 and 3 cycles, modulo 2^PCW.
- R10: Results appear on the clock edge after the request. `out_valid` equals the previous cycle's `in_valid`. In a cycle after one without a request, `out_taken`, `out_next_pc` and `out_cycles` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_kind | input | 3 | Instruction kind, 0..7 as in R2 and R5 to R8 |
| in_sel | input | 3 | Flag index or bit index |
| in_sreg | input | 8 | Status register |
| in_opa | input | DW | First register operand |
| in_opb | input | DW | Second register operand |
| in_io | input | DW | I/O register value |
| in_pc | input | PCW | Program counter of the instruction |
| in_k | input | KW | Branch offset, two's complement |
| in_next_long | input | 1 | Following instruction is two words long |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | Branch taken or skip performed |
| out_next_pc | output | PCW | Program counter that follows |
| out_cycles | output | 2 | Cycles used by the instruction |

## Verification
A taken skip over a two-word instruction and a wrap of the program counter can happen in the same cycle. The bench provokes this with directed requests at the top addresses, and random requests also place the PC there. It judges the result against an independent model that adds modulo 2^PCW. A taken backward branch from address 0 and a forward branch with the largest offset near the top are treated the same way. In those cases the sign extension and the wrap of the offset addition meet in one result.

// File: rtl/bse_pkg.sv
package bse_pkg;
  typedef enum logic [2:0] {
    K_BR_SET   = 3'd0,
    K_BR_CLR   = 3'd1,
    K_SK_EQ    = 3'd2,
    K_SK_RCLR  = 3'd3,
    K_SK_RSET  = 3'd4,
    K_SK_IOCLR = 3'd5,
    K_SK_IOSET = 3'd6,
    K_RSVD     = 3'd7
  } bse_kind_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;
  localparam int FLAG_T = 6;
  localparam int FLAG_I = 7;
  localparam int SREG_W = 8;
endpackage

// File: rtl/bse_cond.sv
module bse_cond
  import bse_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SELW = 3
) (
  input  logic [2:0]        kind,
  input  logic [SELW-1:0]   sel,
  input  logic [SREG_W-1:0] sreg,
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  input  logic [DW-1:0]     io,
  output logic              hit,
  output logic              is_branch
);
  logic flag_val;
  logic opa_bit;
  logic io_bit;
  logic [2:0] fidx;

  assign fidx    = 3'(sel);
  assign opa_bit = opa[sel];
  assign io_bit  = io[sel];

  always_comb begin
    if (int'(fidx) == FLAG_S) flag_val = sreg[FLAG_N] ^ sreg[FLAG_V];
    else                      flag_val = sreg[fidx];
  end

  always_comb begin
    hit       = 1'b0;
    is_branch = 1'b0;
    unique case (bse_kind_e'(kind))
      K_BR_SET:   begin hit = flag_val;  is_branch = 1'b1; end
      K_BR_CLR:   begin hit = !flag_val; is_branch = 1'b1; end
      K_SK_EQ:    hit = (opa == opb);
      K_SK_RCLR:  hit = !opa_bit;
      K_SK_RSET:  hit = opa_bit;
      K_SK_IOCLR: hit = !io_bit;
      K_SK_IOSET: hit = io_bit;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bse_target.sv
module bse_target #(
  parameter int PCW = 10,
  parameter int KW  = 7
) (
  input  logic [PCW-1:0] pc,
  input  logic [KW-1:0]  k,
  input  logic           hit,
  input  logic           is_branch,
  input  logic           next_long,
  output logic [PCW-1:0] next_pc,
  output logic [1:0]     cycles
);
  logic [PCW-1:0] k_ext;
  logic [PCW-1:0] step;

  generate
    if (PCW > KW) begin : g_ext
      assign k_ext = {{(PCW-KW){k[KW-1]}}, k};
    end else begin : g_trunc
      assign k_ext = k[PCW-1:0];
    end
  endgenerate

  always_comb begin
    if (!hit) begin
      step   = PCW'(1);
      cycles = 2'd1;
    end else if (is_branch) begin
      step   = k_ext + PCW'(1);
      cycles = 2'd2;
    end else if (next_long) begin
      step   = PCW'(3);
      cycles = 2'd3;
    end else begin
      step   = PCW'(2);
      cycles = 2'd2;
    end
    next_pc = pc + step;
  end
endmodule

// File: rtl/branch_skip_eval.sv
module branch_skip_eval #(
  parameter int DW  = 8,
  parameter int PCW = 10,
  parameter int KW  = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [2:0]     in_kind,
  input  logic [2:0]     in_sel,
  input  logic [7:0]     in_sreg,
  input  logic [DW-1:0]  in_opa,
  input  logic [DW-1:0]  in_opb,
  input  logic [DW-1:0]  in_io,
  input  logic [PCW-1:0] in_pc,
  input  logic [KW-1:0]  in_k,
  input  logic           in_next_long,
  output logic           out_valid,
  output logic           out_taken,
  output logic [PCW-1:0] out_next_pc,
  output logic [1:0]     out_cycles
);
  localparam int SELW = $clog2(DW);

  logic           c_hit;
  logic           c_branch;
  logic [PCW-1:0] t_pc;
  logic [1:0]     t_cyc;

  bse_cond #(.DW(DW), .SELW(SELW)) u_cond (
    .kind(in_kind), .sel(SELW'(in_sel)), .sreg(in_sreg),
    .opa(in_opa), .opb(in_opb), .io(in_io),
    .hit(c_hit), .is_branch(c_branch)
  );

  bse_target #(.PCW(PCW), .KW(KW)) u_target (
    .pc(in_pc), .k(in_k), .hit(c_hit), .is_branch(c_branch),
    .next_long(in_next_long), .next_pc(t_pc), .cycles(t_cyc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_next_pc <= '0;
      out_cycles  <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken   <= c_hit;
        out_next_pc <= t_pc;
        out_cycles  <= t_cyc;
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_next_pc) && $stable(out_taken)));

  // R5
  not_taken_step_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_taken ||
      (out_cycles == 2'd1 && out_next_pc == PCW'($past(in_pc) + PCW'(1)))));

  // R4
  branch_cycles_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind[2:1] == 2'b00) |=> (!out_taken || out_cycles == 2'd2));

  // R9
  skip_long_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind[2:1] != 2'b00 && in_next_long) |=>
      (!out_taken || (out_cycles == 2'd3 &&
       out_next_pc == PCW'($past(in_pc) + PCW'(3)))));

  // R5
  reserved_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 3'd7) |=> !out_taken);
endmodule

// File: tb/branch_skip_eval_tb.sv
module branch_skip_eval_tb;
  localparam int DW  = 8;
  localparam int PCW = 10;
  localparam int KW  = 7;

  logic           clk = 1'b0;
  logic           rst;
  logic           in_valid;
  logic [2:0]     in_kind;
  logic [2:0]     in_sel;
  logic [7:0]     in_sreg;
  logic [DW-1:0]  in_opa, in_opb, in_io;
  logic [PCW-1:0] in_pc;
  logic [KW-1:0]  in_k;
  logic           in_next_long;
  logic           out_valid, out_taken;
  logic [PCW-1:0] out_next_pc;
  logic [1:0]     out_cycles;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  branch_skip_eval #(.DW(DW), .PCW(PCW), .KW(KW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_sel(in_sel), .in_sreg(in_sreg), .in_opa(in_opa), .in_opb(in_opb),
    .in_io(in_io), .in_pc(in_pc), .in_k(in_k), .in_next_long(in_next_long),
    .out_valid(out_valid), .out_taken(out_taken),
    .out_next_pc(out_next_pc), .out_cycles(out_cycles)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic bit ref_taken(logic [2:0] kind, logic [2:0] sel,
      logic [7:0] sr, logic [7:0] a, logic [7:0] b, logic [7:0] io);
    bit f;
    f = (sel == 3'd4) ? (sr[2] ^ sr[3]) : sr[sel];
    case (kind)
      3'd0: return f;
      3'd1: return !f;
      3'd2: return a == b;
      3'd3: return !a[sel];
      3'd4: return a[sel];
      3'd5: return !io[sel];
      3'd6: return io[sel];
      default: return 1'b0;
    endcase
  endfunction

  function automatic int ref_pc(logic [2:0] kind, bit tk, int pc, logic [6:0] k, bit lng);
    int d;
    if (!tk) d = 1;
    else if (kind <= 3'd1) d = int'($signed(k)) + 1;
    else d = lng ? 3 : 2;
    return (pc + d + 4096) % (1 << PCW);
  endfunction

  function automatic int ref_cyc(logic [2:0] kind, bit tk, bit lng);
    if (!tk) return 1;
    if (kind <= 3'd1) return 2;
    return lng ? 3 : 2;
  endfunction

  task automatic run(string req, logic [2:0] kind, logic [2:0] sel, logic [7:0] sr,
      logic [7:0] a, logic [7:0] b, logic [7:0] io, int pc, logic [6:0] k, bit lng);
    bit tk;
    @(negedge clk);
    in_valid = 1'b1; in_kind = kind; in_sel = sel; in_sreg = sr;
    in_opa = a; in_opb = b; in_io = io; in_pc = PCW'(pc); in_k = k;
    in_next_long = lng;
    tk = ref_taken(kind, sel, sr, a, b, io);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " taken"}, int'(out_taken), int'(tk));
    chk({req, " pc"}, int'(out_next_pc), ref_pc(kind, tk, pc, k, lng));
    chk({req, " cycles"}, int'(out_cycles), ref_cyc(kind, tk, lng));
  endtask

  initial begin
    int seed;
    int prev_pc, prev_tk;
    seed = $urandom(32'h5eed_2024);
    rst = 1'b1; in_valid = 1'b0; in_kind = '0; in_sel = '0; in_sreg = '0;
    in_opa = '0; in_opb = '0; in_io = '0; in_pc = '0; in_k = '0; in_next_long = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 taken", int'(out_taken), 0);
    chk("R1 pc", int'(out_next_pc), 0);
    chk("R1 cycles", int'(out_cycles), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after", int'(out_valid), 0);

    // R2 each flag set/clear, bit order C Z N V S H T I
    for (int s = 0; s < 8; s++) begin
      if (s != 4) begin
        run("R2 set-hit", 3'd0, 3'(s), 8'(1 << s), 0, 0, 0, 100, 7'd5, 0);
        run("R2 clr-miss", 3'd1, 3'(s), 8'(1 << s), 0, 0, 0, 100, 7'd5, 0);
        run("R2 set-miss", 3'd0, 3'(s), ~8'(1 << s), 0, 0, 0, 100, 7'd5, 0);
      end
    end
    // R3 signed flag from N^V, stored bit 4 ignored
    run("R3 nv10 s0", 3'd0, 3'd4, 8'b0000_0100, 0, 0, 0, 50, 7'd3, 0);
    run("R3 nv11 s1", 3'd0, 3'd4, 8'b0001_1100, 0, 0, 0, 50, 7'd3, 0);
    run("R3 nv01 clr", 3'd1, 3'd4, 8'b0000_1000, 0, 0, 0, 50, 7'd3, 0);
    run("R3 nv00 s1 clr", 3'd1, 3'd4, 8'b0001_0000, 0, 0, 0, 50, 7'd3, 0);
    // R4 offset extremes and wrap
    run("R4 back wrap", 3'd0, 3'd0, 8'h01, 0, 0, 0, 0, 7'h40, 0);
    run("R4 fwd wrap", 3'd0, 3'd0, 8'h01, 0, 0, 0, 1020, 7'h3f, 0);
    run("R4 k=-1", 3'd1, 3'd1, 8'h00, 0, 0, 0, 10, 7'h7f, 0);
    // R5 reserved kind and pc wrap
    run("R5 reserved", 3'd7, 3'd0, 8'hff, 8'h11, 8'h11, 8'h00, 1023, 7'd9, 1);
    // R6
    run("R6 eq", 3'd2, 3'd0, 8'h00, 8'h5a, 8'h5a, 0, 200, 0, 0);
    run("R6 ne", 3'd2, 3'd0, 8'h00, 8'h5a, 8'h5b, 0, 200, 0, 0);
    // R7
    run("R7 rclr", 3'd3, 3'd6, 8'h00, 8'hbf, 0, 0, 300, 0, 0);
    run("R7 rset", 3'd4, 3'd7, 8'h00, 8'h80, 0, 0, 300, 0, 1);
    // R8
    run("R8 ioclr", 3'd5, 3'd2, 8'h00, 8'hff, 0, 8'hfb, 400, 0, 0);
    run("R8 ioset", 3'd6, 3'd2, 8'h00, 8'h00, 0, 8'h04, 400, 0, 1);
    // R9 long skip at the top with wrap
    run("R9 long wrap", 3'd2, 3'd0, 8'h00, 8'h33, 8'h33, 0, 1022, 0, 1);
    run("R9 short wrap", 3'd4, 3'd0, 8'h00, 8'h01, 0, 0, 1023, 0, 0);

    // R10 idle cycle holds outputs
    prev_pc = int'(out_next_pc); prev_tk = int'(out_taken);
    @(negedge clk);
    chk("R10 idle valid", int'(out_valid), 0);
    chk("R10 hold pc", int'(out_next_pc), prev_pc);
    chk("R10 hold taken", int'(out_taken), prev_tk);

    // random mix, R2..R9
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom);
      b = ($urandom % 4 == 0) ? a : 8'($urandom);
      run("R2-R9 rand", 3'($urandom), 3'($urandom), 8'($urandom), a, b,
          8'($urandom), int'($urandom % 1024), 7'($urandom), bit'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule